// File: doc/BRIEF.md
# External Watchdog Monitor

This block checks from outside that the software on a processor is still running. It has a byte-wide synchronous register bus with two locations. One is a control register. The other is a write-only service location. While the block is enabled, a cycle counter runs. Software must restart that counter before it reaches its limit. It does this by writing a two-byte key to the service location in the right order, with the second byte close enough in time to the first. If the counter reaches its limit, or a service write is wrong, the block raises a sticky fail output. The system can use that output to hold a subsystem in a safe state.

The block also watches an external pin. The pin's active level can be chosen, and it can be switched off. When the pin is active, the fail output is raised as well. An interrupt output follows the fail output when the interrupt is enabled. The enable bit and the pin set-up can be written only once after reset. This keeps a runaway program from switching the monitor off.

Top module: `xwd_monitor`

## Requirements
- R1: After reset, `fail_out` and `irq_out` are 0 and both register locations read 0x00.
- R2: A read returns data on `bus_rdata` one clock edge after the address is presented. The control location (offset 0) returns {4'b0, irq_en, pin_en, pin_pol, mod_en} in bits 7..0, so bits 7..4 always read 0. The service location (offset 1) and every other address read 0x00.
- R3: The first control write after reset sets bits 2..0 (pin_en, pin_pol, mod_en). Later writes leave those bits unchanged. Bit 3 (irq_en) takes the written value on every control write. If the first write leaves mod_en at 0, the block stays disabled until reset.
- R4: While mod_en is 0, `fail_out` and `irq_out` stay 0 and service writes have no effect.
- R5: Assume no legal service takes place. Count the clock edge that performs the enabling write as edge 0. Then `fail_out` is 0 after edge TIMEOUT-1 and 1 after edge TIMEOUT.
- R6: A legal service is a write of KEY_FIRST (0xB4) to offset 1, then a write of KEY_SECOND (0x2C) to offset 1. The second write must come 1 to SVC_WIN clock edges after the first. A legal service restarts the count, so `fail_out` rises TIMEOUT edges after the second write unless the block is serviced again.
- R7: An illegal service sets `fail_out` at the edge of the offending write. This covers a byte other than KEY_FIRST when no first byte is pending, and any byte other than KEY_SECOND when one is pending. If no second write arrives within SVC_WIN edges, the pending first byte is dropped. The next write is then judged as a first byte.
- R8: Once set, `fail_out` stays 1. It is cleared only by reset, or by a legal service completed while the pin is not active.
- R9: While pin_en and mod_en are 1, the pin is active when `ext_in` equals pin_pol (low when pin_pol=0, high when pin_pol=1). An active pin sets `fail_out` at the third edge after the change (SYNC_STAGES=2). While pin_en is 0, the pin has no effect.
- R10: `irq_out` equals, one edge later, `fail_out` AND irq_en. Writing irq_en to 0 removes the request while `fail_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. Hold it for at least SYNC_STAGES cycles |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| ext_in | input | 1 | External monitored pin, asynchronous |
| fail_out | output | 1 | Registered sticky fail indication |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A table of key pairs drives the service path. Each row gives a first byte, a gap and a second byte. The rows separate a legal service, a service at the exact edge where the window closes, a service one edge too late, swapped key order, a repeated first key and single-bit errors in either key. Directed runs measure the timeout edge exactly, with and without a service made just before the limit. These runs show whether the count truly restarts. They also drive the pin at each polarity, and with pin monitoring switched off, to separate the active level from the inactive one. The interrupt is checked against the timing of the fail output. So are the write-once control bits and the bit that stays writable.

// File: rtl/xwd_pkg.sv
package xwd_pkg;

  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 4;
  localparam int OFS_CTRL = 0;
  localparam int OFS_SVC  = 1;

  // Control field layout, bit 3 down to bit 0.
  typedef struct packed {
    logic irq_en;
    logic pin_en;
    logic pin_pol;
    logic mod_en;
  } ctrl_t;

  typedef enum logic {
    SVC_IDLE,
    SVC_ARMED
  } svc_st_e;

endpackage

// File: rtl/xwd_ctrl_reg.sv
module xwd_ctrl_reg
  import xwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              en_start
);

  logic  locked_q;
  ctrl_t wr_fields;

  assign wr_fields = ctrl_t'(wdata);
  // Pulse on the single write that turns the monitor on.
  assign en_start  = wr_en && !locked_q && wr_fields.mod_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      locked_q <= 1'b0;
    end else if (wr_en) begin
      ctrl.irq_en <= wr_fields.irq_en;
      if (!locked_q) begin
        locked_q     <= 1'b1;
        ctrl.pin_en  <= wr_fields.pin_en;
        ctrl.pin_pol <= wr_fields.pin_pol;
        ctrl.mod_en  <= wr_fields.mod_en;
      end
    end
  end

endmodule

// File: rtl/xwd_pin_sync.sv
module xwd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  // No reset: the chain keeps sampling while rst is held, so it is
  // filled with the real pin level by the time reset is released.
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk) s_q <= d;
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) s_q <= {s_q[STAGES-2:0], d};
      assign q = s_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/xwd_service.sv
module xwd_service
  import xwd_pkg::*;
#(
  parameter int          SVC_WIN    = 256,
  parameter logic [7:0]  KEY_FIRST  = 8'hB4,
  parameter logic [7:0]  KEY_SECOND = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_svc,
  input  logic [DATA_W-1:0] wdata,
  output logic              svc_ok,
  output logic              svc_bad
);

  localparam int WIN_W = $clog2(SVC_WIN + 1);

  svc_st_e          st_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q  <= SVC_IDLE;
      win_q <= '0;
    end else begin
      unique case (st_q)
        SVC_IDLE: begin
          if (wr_svc && (wdata == KEY_FIRST)) begin
            st_q  <= SVC_ARMED;
            win_q <= WIN_W'(1);
          end
        end
        SVC_ARMED: begin
          if (wr_svc) begin
            st_q <= SVC_IDLE;
          end else if (win_q == WIN_W'(SVC_WIN)) begin
            st_q <= SVC_IDLE;   // window closed, pending key dropped
          end else begin
            win_q <= win_q + WIN_W'(1);
          end
        end
        default: st_q <= SVC_IDLE;
      endcase
    end
  end

  always_comb begin
    svc_ok  = 1'b0;
    svc_bad = 1'b0;
    if (en && wr_svc) begin
      if (st_q == SVC_ARMED) begin
        svc_ok  = (wdata == KEY_SECOND);
        svc_bad = (wdata != KEY_SECOND);
      end else begin
        svc_bad = (wdata != KEY_FIRST);
      end
    end
  end

endmodule

// File: rtl/xwd_timer.sv
module xwd_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic en_start,
  input  logic svc_ok,
  input  logic svc_bad,
  input  logic pin_hit,
  output logic fail_q
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = !svc_ok && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst || en_start) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (en) begin
      if (svc_ok) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_W'(TIMEOUT)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      // Set conditions win over the clearing service.
      if (svc_bad || pin_hit || expire) begin
        fail_q <= 1'b1;
      end else if (svc_ok) begin
        fail_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xwd_monitor.sv
module xwd_monitor
  import xwd_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         SVC_WIN     = 256,
  parameter int         TIMEOUT     = 1024,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] KEY_FIRST   = 8'hB4,
  parameter logic [7:0] KEY_SECOND  = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_in,
  output logic              fail_out,
  output logic              irq_out
);

  localparam int PAD_W = DATA_W - CTRL_W;

  logic  sel_ctrl;
  logic  sel_svc;
  ctrl_t ctrl_q;
  logic  en_start;
  logic  pin_s;
  logic  pin_hit;
  logic  svc_ok;
  logic  svc_bad;
  logic  fail_q;
  logic  irq_q;
  logic [DATA_W-1:0] rdata_q;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_svc  = (bus_addr == ADDR_W'(OFS_SVC));

  xwd_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && sel_ctrl),
    .wdata    (bus_wdata[CTRL_W-1:0]),
    .ctrl     (ctrl_q),
    .en_start (en_start)
  );

  xwd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (ext_in),
    .q   (pin_s)
  );

  assign pin_hit = ctrl_q.pin_en && (pin_s ~^ ctrl_q.pin_pol);

  xwd_service #(
    .SVC_WIN    (SVC_WIN),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_svc (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_q.mod_en),
    .wr_svc  (bus_wr && sel_svc),
    .wdata   (bus_wdata),
    .svc_ok  (svc_ok),
    .svc_bad (svc_bad)
  );

  xwd_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q.mod_en),
    .en_start (en_start),
    .svc_ok   (svc_ok),
    .svc_bad  (svc_bad),
    .pin_hit  (pin_hit),
    .fail_q   (fail_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= sel_ctrl ? {{PAD_W{1'b0}}, ctrl_q} : '0;
      irq_q   <= fail_q && ctrl_q.irq_en;
    end
  end

  assign bus_rdata = rdata_q;
  assign fail_out  = fail_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/xwd_monitor_chk.sv
module xwd_monitor_chk
  import xwd_pkg::*;
#(
  parameter int         ADDR_W     = 4,
  parameter logic [7:0] KEY_FIRST  = 8'hB4,
  parameter logic [7:0] KEY_SECOND = 8'h2C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              fail_out,
  input logic              irq_out,
  input ctrl_t             ctrl
);

  logic svc_wr;
  assign svc_wr = bus_wr && (bus_addr == ADDR_W'(OFS_SVC));

  AST_NONCTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != ADDR_W'(OFS_CTRL)) |=> (bus_rdata == 8'h00)); // R2

  AST_ENABLE_KEPT: assert property (@(posedge clk) disable iff (rst)
    ctrl.mod_en |=> ctrl.mod_en); // R3

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.mod_en |-> (!fail_out && !irq_out)); // R4

  AST_BAD_KEY_FAILS: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mod_en && svc_wr && (bus_wdata != KEY_FIRST) && (bus_wdata != KEY_SECOND))
      |=> fail_out); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_out && !(svc_wr && (bus_wdata == KEY_SECOND))) |=> fail_out); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (fail_out && ctrl.irq_en) |=> irq_out); // R10

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(fail_out && ctrl.irq_en) |=> !irq_out); // R10

endmodule

bind xwd_monitor xwd_monitor_chk #(
  .ADDR_W     (ADDR_W),
  .KEY_FIRST  (KEY_FIRST),
  .KEY_SECOND (KEY_SECOND)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .fail_out  (fail_out),
  .irq_out   (irq_out),
  .ctrl      (ctrl_q)
);

// File: tb/xwd_monitor_tb.sv
`timescale 1ns/1ps
module xwd_monitor_tb;

  localparam int ADDR_W  = 4;
  localparam int SVC_WIN = 8;
  localparam int TIMEOUT = 40;

  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] gap;
    logic [7:0] b2;
    logic       exp_fail;
  } vec_t;

  // gap g puts the second write g+2 edges after the first.
  localparam vec_t VEC [0:6] = '{
    '{8'hB4, 8'd0,          8'h2C, 1'b0},
    '{8'hB4, 8'(SVC_WIN-2), 8'h2C, 1'b0},
    '{8'hB4, 8'(SVC_WIN-1), 8'h2C, 1'b1},
    '{8'h2C, 8'd0,          8'hB4, 1'b1},
    '{8'hB4, 8'd0,          8'hB4, 1'b1},
    '{8'hB5, 8'd0,          8'h2C, 1'b1},
    '{8'hB4, 8'd3,          8'h2D, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              ext_in = 1'b1;
  logic              fail_out;
  logic              irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  xwd_monitor #(
    .ADDR_W  (ADDR_W),
    .SVC_WIN (SVC_WIN),
    .TIMEOUT (TIMEOUT)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_in    (ext_in),
    .fail_out  (fail_out),
    .irq_out   (irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin_level);
    @(negedge clk);
    rst    = 1'b1;
    bus_wr = 1'b0;
    ext_in = pin_level;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    bus_wr   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic service();
    bus_write(1, 8'hB4);
    bus_write(1, 8'h2C);
  endtask

  initial begin
    // R1 reset state
    do_reset(1'b1);
    chk("R1 fail", {7'b0, fail_out}, 8'h00);
    chk("R1 irq",  {7'b0, irq_out},  8'h00);
    bus_read(0, rd); chk("R1 ctrl read", rd, 8'h00);
    bus_read(1, rd); chk("R1 svc read",  rd, 8'h00);

    // Vector table: service key pairs (R6 legal, R7 illegal)
    for (int i = 0; i < 7; i++) begin
      do_reset(1'b1);
      bus_write(0, 8'h01);
      bus_write(1, VEC[i].b1);
      idle(int'(VEC[i].gap));
      bus_write(1, VEC[i].b2);
      idle(1);
      chk(VEC[i].exp_fail ? "R7 vector" : "R6 vector",
          {7'b0, fail_out}, {7'b0, VEC[i].exp_fail});
    end

    // R2 / R3 readback and write-once bits
    do_reset(1'b1);
    bus_write(0, 8'hFF);
    bus_read(0, rd); chk("R2 reserved bits", rd, 8'h0F);
    bus_write(0, 8'h00);
    bus_read(0, rd); chk("R3 locked bits kept", rd, 8'h07);
    bus_write(0, 8'h08);
    bus_read(0, rd); chk("R3 irq_en rewritable", rd, 8'h0F);
    bus_write(1, 8'hB4);
    bus_read(1, rd); chk("R2 svc reads zero", rd, 8'h00);
    bus_read(2, rd); chk("R2 unmapped reads zero", rd, 8'h00);

    // R3 / R4 enable cleared by first write stays off
    do_reset(1'b1);
    bus_write(0, 8'h00);
    bus_write(0, 8'h09);
    bus_read(0, rd); chk("R3 enable not re-armed", rd, 8'h08);
    bus_write(1, 8'h55);
    ext_in = 1'b0;
    idle(TIMEOUT + 5);
    chk("R4 disabled fail", {7'b0, fail_out}, 8'h00);
    chk("R4 disabled irq",  {7'b0, irq_out},  8'h00);

    // R5 exact timeout edge
    do_reset(1'b1);
    bus_write(0, 8'h01);
    idle(TIMEOUT - 1);
    chk("R5 before limit", {7'b0, fail_out}, 8'h00);
    idle(1);
    chk("R5 at limit", {7'b0, fail_out}, 8'h01);
    chk("R10 irq off when disabled", {7'b0, irq_out}, 8'h00);

    // R6 service restarts the count
    do_reset(1'b1);
    bus_write(0, 8'h01);
    idle(TIMEOUT - 10);
    service();
    idle(TIMEOUT - 1);
    chk("R6 restarted before limit", {7'b0, fail_out}, 8'h00);
    idle(1);
    chk("R6 restarted at limit", {7'b0, fail_out}, 8'h01);

    // R7 / R8 illegal write, stickiness, clear
    do_reset(1'b1);
    bus_write(0, 8'h01);
    bus_write(1, 8'h55);
    chk("R7 bad byte at write edge", {7'b0, fail_out}, 8'h01);
    idle(5);
    chk("R8 sticky", {7'b0, fail_out}, 8'h01);
    service();
    chk("R8 cleared by service", {7'b0, fail_out}, 8'h00);

    // R9 active-low pin
    do_reset(1'b1);
    bus_write(0, 8'h05);
    idle(5);
    chk("R9 low pin inactive", {7'b0, fail_out}, 8'h00);
    ext_in = 1'b0;
    idle(2);
    chk("R9 latency not yet", {7'b0, fail_out}, 8'h00);
    idle(1);
    chk("R9 active-low hit", {7'b0, fail_out}, 8'h01);
    ext_in = 1'b1;
    idle(4);
    chk("R8 held after pin release", {7'b0, fail_out}, 8'h01);
    service();
    chk("R8 clear with pin inactive", {7'b0, fail_out}, 8'h00);
    ext_in = 1'b0;
    idle(4);
    service();
    chk("R8 no clear with pin active", {7'b0, fail_out}, 8'h01);

    // R9 active-high pin
    do_reset(1'b0);
    bus_write(0, 8'h07);
    idle(5);
    chk("R9 high pin inactive", {7'b0, fail_out}, 8'h00);
    ext_in = 1'b1;
    idle(3);
    chk("R9 active-high hit", {7'b0, fail_out}, 8'h01);

    // R9 pin disabled
    do_reset(1'b1);
    bus_write(0, 8'h01);
    ext_in = 1'b0;
    idle(8);
    chk("R9 pin ignored", {7'b0, fail_out}, 8'h00);

    // R10 interrupt
    do_reset(1'b1);
    bus_write(0, 8'h09);
    bus_write(1, 8'h00);
    chk("R10 fail set", {7'b0, fail_out}, 8'h01);
    chk("R10 irq lags", {7'b0, irq_out},  8'h00);
    idle(1);
    chk("R10 irq raised", {7'b0, irq_out}, 8'h01);
    bus_write(0, 8'h01);
    idle(1);
    chk("R10 irq removed", {7'b0, irq_out}, 8'h00);
    chk("R10 fail kept",   {7'b0, fail_out}, 8'h01);
    bus_write(0, 8'h09);
    idle(1);
    chk("R10 irq re-enabled", {7'b0, irq_out}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule